// File: doc/BRIEF.md
# Programmable Interval Timer with Compare Match

The block is an 8-bit up-counter that advances on a tick taken from a prescaled system clock. It is compared against a programmable constant. When the counter leaves the value equal to the constant, a status flag is set and the counter returns to zero. If interrupts are enabled and the memory refresh field is zero, an interrupt request follows. Software controls the block through a four-word register port. It can read and write the counter, the constant, a control/status word, and a mode word that holds a 3-bit refresh-enable field. Any nonzero value in that field marks the counter as in use for memory refresh and masks the interval interrupt.

A match is taken only on the tick that would move the counter off the matching value, not in the cycle where equality first appears. A period programmed as constant C therefore spans C+1 ticks. The flag can be cleared only through a read-then-write sequence, so a request that arrives while software is servicing the previous one is not lost.

Top module: `ivt_timer`

## Requirements
- R1: After a synchronous reset the control word reads 0x00, the counter 0x00, the constant 0xFF and the mode word 0x00, and `irq` is 0.
- R2: Register addresses: 0 = control (bits 2:0 clock select, bit 6 interrupt enable, bit 7 match flag, other bits read 0), 1 = counter, 2 = constant, 3 = mode (bits 2:0 refresh field, other bits read 0). Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.
- R3: Clock select 0 stops the counter. Values 1 to 7 give one tick every 2, 8, 32, 128, 512, 2048 and 4096 clocks. The counter adds 1 per tick.
- R4: Equality of counter and constant alone sets nothing. On the next tick the counter becomes 0 instead of incrementing, and the flag is set at that same edge.
- R5: `irq` is a register equal to flag AND interrupt enable AND (mode field == 0). It rises at the same edge as the flag.
- R6: A control write with bit 7 = 0 clears the flag only if the flag was read as 1 since it was last set. Writing 1 to bit 7 has no effect.
- R7: If a clear and a new match fall on the same edge, the flag stays set.
- R8: A counter write takes priority over an increment or a match clear on the same edge.
- R9: A control write that changes the clock select restarts the prescaler. The first tick then arrives exactly one full divide period after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Compare-match interrupt request |

## Verification
The bench measures the exact number of edges from the programming write to the interrupt. This catches a design that matches on equality (too early by one tick) or lets the prescaler run on across a select change (irq early or at a random phase). It arms the flag and then issues clears at every phase against a match that recurs every tick. A design that lets the clear win would drop a request. Further cases: clears without a prior read, writes of 1 to the flag, and a nonzero mode field, where a careless design would clear or raise the interrupt. Random register traffic then checks counter-write priority and read data against a cycle model.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_MODE = 2'd3;

  // Number of prescaler bits that must be all ones for a tick.
  function automatic int unsigned div_log2(input logic [2:0] sel);
    case (sel)
      3'd1: div_log2 = 1;
      3'd2: div_log2 = 3;
      3'd3: div_log2 = 5;
      3'd4: div_log2 = 7;
      3'd5: div_log2 = 9;
      3'd6: div_log2 = 11;
      3'd7: div_log2 = 12;
      default: div_log2 = 0;
    endcase
  endfunction
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
  parameter int PRE_W = 12,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             tick
);
  import ivt_pkg::*;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < int'(div_log2(3'(sel)))) mask[i] = 1'b1;
  end

  assign tick = (sel != '0) && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cmp,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         match
);
  logic [W-1:0] cnt_q;

  assign match = tick && (cnt_q == cmp);
  assign cnt   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (wr_en) cnt_q <= wdata;
    else if (match) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  // R4
  match_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (match && !wr_en) |=> (cnt_q == '0));
  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable(cnt_q));
  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs #(
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [W-1:0]     wdata,
  input  logic             match,
  input  logic [W-1:0]     cnt,
  output logic [SEL_W-1:0] sel,
  output logic             restart,
  output logic [W-1:0]     cmp,
  output logic             cnt_wr,
  output logic [W-1:0]     rdata,
  output logic             irq
);
  import ivt_pkg::*;
  logic [SEL_W-1:0] sel_q, sel_d, mode_q, mode_d;
  logic             ie_q, ie_d, flag_q, flag_d, armed_q, armed_d, irq_q;
  logic [W-1:0]     cmp_q, cmp_d, rdata_q, rsel;
  logic             wr_ctrl, clr;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign clr     = wr_ctrl && !wdata[W-1] && armed_q;
  assign restart = wr_ctrl && (wdata[SEL_W-1:0] != sel_q);
  assign cnt_wr  = wr && (addr == A_CNT);

  always_comb begin
    sel_d  = wr_ctrl ? wdata[SEL_W-1:0] : sel_q;
    ie_d   = wr_ctrl ? wdata[W-2] : ie_q;
    cmp_d  = (wr && addr == A_CMP) ? wdata : cmp_q;
    mode_d = (wr && addr == A_MODE) ? wdata[SEL_W-1:0] : mode_q;
    if (match)    flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
    armed_d = flag_d && (armed_q || (rd && addr == A_CTRL && flag_q));
  end

  always_comb begin
    rsel = '0;
    case (addr)
      A_CTRL: begin
        rsel[SEL_W-1:0] = sel_q;
        rsel[W-2]       = ie_q;
        rsel[W-1]       = flag_q;
      end
      A_CNT:  rsel = cnt;
      A_CMP:  rsel = cmp_q;
      default: rsel[SEL_W-1:0] = mode_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0; ie_q <= 1'b0; flag_q <= 1'b0; armed_q <= 1'b0;
      cmp_q <= '1; mode_q <= '0; rdata_q <= '0; irq_q <= 1'b0;
    end else begin
      sel_q <= sel_d; ie_q <= ie_d; flag_q <= flag_d; armed_q <= armed_d;
      cmp_q <= cmp_d; mode_q <= mode_d;
      if (rd) rdata_q <= rsel;
      irq_q <= flag_d && ie_d && (mode_d == '0);
    end
  end

  assign sel   = sel_q;
  assign cmp   = cmp_q;
  assign rdata = rdata_q;
  assign irq   = irq_q;

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && ie_q && mode_q == '0));
  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    match |=> flag_q);
  // R6
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(armed_q));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 12,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  logic [SEL_W-1:0] sel;
  logic             restart, tick, match, cnt_wr;
  logic [CNT_W-1:0] cmp, cnt;

  ivt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .sel(sel), .restart(restart), .tick(tick));

  ivt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cmp(cmp), .wr_en(cnt_wr),
    .wdata(bus_wdata), .cnt(cnt), .match(match));

  ivt_regs #(.W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .match(match), .cnt(cnt), .sel(sel),
    .restart(restart), .cmp(cmp), .cnt_wr(cnt_wr), .rdata(bus_rdata),
    .irq(irq));
endmodule

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
  localparam int CLK_PERIOD = 10;
  logic       clk = 1'b0, rst = 1'b1, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0, rdata;
  logic       irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivt_timer u0 (.clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wd), .bus_rdata(rdata), .irq(irq));

  // Reference model built from the requirements
  logic [7:0] m_cnt, m_cmp, m_rd;
  logic [2:0] m_sel, m_mode;
  logic m_ie, m_flag, m_armed, m_irq;
  int m_pre;

  function automatic int divof(input logic [2:0] s);
    case (s)
      3'd1: return 2;    3'd2: return 8;    3'd3: return 32;
      3'd4: return 128;  3'd5: return 512;  3'd6: return 2048;
      default: return 4096;
    endcase
  endfunction

  always @(posedge clk) begin
    logic tk, mt, fl;
    if (rst) begin
      m_cnt = 0; m_cmp = 8'hFF; m_rd = 0; m_sel = 0; m_mode = 0;
      m_ie = 0; m_flag = 0; m_armed = 0; m_irq = 0; m_pre = 0;
    end else begin
      tk = (m_sel != 0) && ((m_pre % divof(m_sel)) == divof(m_sel) - 1);
      mt = tk && (m_cnt == m_cmp);
      if (rd)
        case (addr)
          2'd0: m_rd = {m_flag, m_ie, 3'b000, m_sel};
          2'd1: m_rd = m_cnt;
          2'd2: m_rd = m_cmp;
          default: m_rd = {5'b0, m_mode};
        endcase
      fl = mt ? 1'b1 : (wr && addr == 0 && !wd[7] && m_armed) ? 1'b0 : m_flag;
      m_armed = fl && (m_armed || (rd && addr == 0 && m_flag));
      m_flag = fl;
      if (wr && addr == 1) m_cnt = wd;
      else if (mt) m_cnt = 0;
      else if (tk) m_cnt = m_cnt + 1;
      m_pre = (wr && addr == 0 && wd[2:0] != m_sel) ? 0 : m_pre + 1;
      if (wr && addr == 0) begin m_sel = wd[2:0]; m_ie = wd[6]; end
      if (wr && addr == 2) m_cmp = wd;
      if (wr && addr == 3) m_mode = wd[2:0];
      m_irq = m_flag && m_ie && (m_mode == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model (R2 R3 R4 R5 R6 R7 R8)
  always @(negedge clk) if (!rst) begin
    chk(irq == m_irq, "R5 irq vs model", irq, m_irq);
    chk(rdata == m_rd, "R2 rdata vs model", rdata, m_rd);
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr = 1; addr = a; wd = d; @(negedge clk); wr = 0;
  endtask
  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    rd = 1; addr = a; @(negedge clk); rd = 0; d = rdata;
  endtask
  task automatic do_reset();
    rst = 1; wr = 0; rd = 0; idle(2); rst = 0;
  endtask
  task automatic edges_to_irq(output int n);
    n = 0;
    while (!irq && n < 10000) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd20240611));
    @(negedge clk); do_reset();
    // R1 reset values
    chk(irq == 0, "R1 irq", irq, 0);
    rreg(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    rreg(2'd1, v); chk(v == 8'h00, "R1 cnt", v, 8'h00);
    rreg(2'd2, v); chk(v == 8'hFF, "R1 cmp", v, 8'hFF);
    rreg(2'd3, v); chk(v == 8'h00, "R1 mode", v, 8'h00);

    // R4: cmp=2, divide 2 -> counter 0,1,2 then match on the tick leaving 2
    wreg(2'd2, 8'd2);
    wreg(2'd0, 8'h41);
    edges_to_irq(n); chk(n == 6, "R4 edges to match", n, 6);
    rreg(2'd0, v); chk(v == 8'hC1, "R2 ctrl with flag", v, 8'hC1);

    // R9 + R3: cmp=0, divide 32 -> first tick 32 edges after select write
    do_reset();
    wreg(2'd2, 8'd0);
    wreg(2'd0, 8'h43);
    edges_to_irq(n); chk(n == 32, "R9 restart period", n, 32);

    // R6: clear without prior read is ignored, writing 1 is ignored
    do_reset();
    wreg(2'd2, 8'd1); wreg(2'd0, 8'h41); edges_to_irq(n);
    wreg(2'd0, 8'h40);
    chk(irq == 1, "R6 clear without read", irq, 1);
    rreg(2'd0, v); chk(v == 8'hC0, "R6 flag read", v, 8'hC0);
    wreg(2'd0, 8'h40);
    chk(irq == 0, "R6 clear after read", irq, 0);
    wreg(2'd0, 8'hC0); idle(1);
    rreg(2'd0, v); chk(v == 8'h40, "R6 write one ignored", v, 8'h40);

    // R5: mode field masks the interrupt
    wreg(2'd0, 8'h41); edges_to_irq(n); wreg(2'd0, 8'h40);
    wreg(2'd3, 8'h02);
    chk(irq == 0, "R5 mode masks irq", irq, 0);
    wreg(2'd3, 8'h00);
    chk(irq == 1, "R5 mode cleared", irq, 1);

    // R7: clear at every phase against a match on every tick
    do_reset();
    wreg(2'd2, 8'd0); wreg(2'd0, 8'h41); edges_to_irq(n);
    for (int off = 0; off < 4; off++) begin
      rreg(2'd0, v); idle(off); wreg(2'd0, 8'h41); idle(1);
    end

    // R8: counter writes at every phase while ticking
    do_reset();
    wreg(2'd2, 8'd5); wreg(2'd0, 8'h41);
    for (int k = 0; k < 4; k++) begin
      wreg(2'd1, 8'd5); idle(k);
      rreg(2'd1, v);
    end

    // Constrained random traffic checked against the model (R2 R3 R4 R6 R7 R8)
    do_reset();
    wreg(2'd2, 8'd3); wreg(2'd0, 8'h41);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 55) idle(1);
      else if (r < 80) rreg(2'($urandom_range(0, 3)), v);
      else begin
        logic [1:0] a;
        logic [7:0] d;
        a = 2'($urandom_range(0, 3));
        case (a)
          2'd0: d = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'b000,
                     ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 3)) : 3'($urandom_range(1, 2))};
          2'd1: d = 8'($urandom_range(0, 7));
          2'd2: d = 8'($urandom_range(0, 7));
          default: d = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(1, 7)) : 8'd0;
        endcase
        wreg(a, d);
      end
    end
    idle(2);
    report();
  end
endmodule